// File: doc/BRIEF.md
# Color Bar Line Pattern Generator

This block produces one video line of an eight-bar color test pattern as packed payload bytes, one byte per clock, for a camera-style serial link. The caller chooses the raw pixel format and the line length in pixels. A built-in sizing helper converts the length into packed blocks and then into bytes. From that it derives the width of each bar, rounded down so that the eight bars split the line evenly.

A start strobe loads the computed sizes and begins the line. Bytes leave through a valid/ready handshake. Each byte carries the current bar number, and the last byte of the line carries an end-of-line flag. When a length cannot be packed, or is too short to give every bar at least one block, the block raises a one-cycle error pulse and sends nothing. Packet headers, checksums, line and frame timing, and serialization are handled by the neighbouring blocks.

Top module: `cbar_pattern_gen`

## Requirements
- R1: `dtype_sel`=0 selects 10-bit raw packing, where one block is 5 bytes holding 4 pixels. `dtype_sel`=1 selects 12-bit raw packing, where one block is 3 bytes holding 2 pixels. A line carries exactly (pixels / pixels-per-block) * bytes-per-block bytes.
- R2: The bar width in bytes is floor(blocks / 8) * bytes-per-block. Bar 0 comes first, and `out_bar` advances by one after exactly that many transferred bytes, up to bar 7.
- R3: Every byte of bar i carries table entry i. The default table, indexed 0 to 7, is FF, E0, C3, 96, 69, 3C, 1F, 00 (hex).
- R4: Bytes left over after eight full bars, which exist because of the rounding down, carry the bar 7 value, and `out_bar` stays at 7.
- R5: A byte transfers only on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_byte`, `out_bar` and `out_eol` hold their values.
- R6: `out_eol` is high exactly on the final byte of the line. After that byte transfers, `out_valid` falls.
- R7: A strobe taken while idle with a length that is not a whole number of blocks, or that has fewer than 8 blocks (including zero), raises `len_err` for exactly one cycle and produces no valid byte.
- R8: A strobe that arrives while a line is in progress is ignored, including on the cycle of the final transfer. The line in progress continues with its loaded sizes, and no new line starts.
- R9: After reset, `out_valid`, `out_eol` and `len_err` are low and `out_bar` is 0.
- R10: After an accepted strobe, `out_valid` is high on the following cycle with `out_bar` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dtype_sel | input | 1 | Raw format: 0 = 10-bit, 1 = 12-bit |
| pix_len | input | PIX_W | Line length in pixels, sampled on the strobe |
| sol_strobe | input | 1 | Start-of-line request |
| out_ready | input | 1 | Downstream can take a byte |
| out_byte | output | BYTE_W | Payload byte |
| out_valid | output | 1 | `out_byte` is valid |
| out_bar | output | 3 | Bar number of the current byte |
| out_eol | output | 1 | Current byte is the last of the line |
| len_err | output | 1 | One-cycle pulse for a rejected length |

## Verification
Two events can land on the same edge: a new start strobe and the acceptance of the final byte. The bench raises the strobe in exactly the cycle where the last byte transfers, and does the same in the middle of lines with a different length on `pix_len`. It then judges the result by the byte stream continuing with the old sizes and by `out_valid` staying low afterward. A second coincidence is a back-pressure stall that falls on a bar boundary. Pseudo-random ready patterns provoke it, and the bench checks that the held byte and bar number do not change during the stall.

// File: rtl/cbar_pkg.sv
package cbar_pkg;
  localparam int NUM_BARS  = 8;
  localparam int BAR_IDX_W = 3;

  typedef enum logic {
    DT_RAW10 = 1'b0,
    DT_RAW12 = 1'b1
  } dtype_e;
endpackage

// File: rtl/cbar_size_calc.sv
module cbar_size_calc #(
  parameter int PIX_W = 14,
  localparam int LB_W = PIX_W + 1
) (
  input  cbar_pkg::dtype_e   dtype,
  input  logic [PIX_W-1:0]   pix_len,
  output logic               len_ok,
  output logic [LB_W-1:0]    bar_bytes,
  output logic [LB_W-1:0]    line_bytes
);
  logic [PIX_W-1:0] blocks;
  logic             partial;
  logic [LB_W-1:0]  blk_w;
  logic [LB_W-1:0]  bar_blk_w;

  always_comb begin
    if (dtype == cbar_pkg::DT_RAW12) begin
      blocks  = {1'b0, pix_len[PIX_W-1:1]};
      partial = pix_len[0];
    end else begin
      blocks  = {2'b00, pix_len[PIX_W-1:2]};
      partial = |pix_len[1:0];
    end
    blk_w     = LB_W'(blocks);
    bar_blk_w = LB_W'(blocks >> 3);
    if (dtype == cbar_pkg::DT_RAW12) begin
      line_bytes = (blk_w << 1) + blk_w;
      bar_bytes  = (bar_blk_w << 1) + bar_blk_w;
    end else begin
      line_bytes = (blk_w << 2) + blk_w;
      bar_bytes  = (bar_blk_w << 2) + bar_blk_w;
    end
    len_ok = !partial && (blocks >= PIX_W'(cbar_pkg::NUM_BARS));
  end
endmodule

// File: rtl/cbar_palette.sv
module cbar_palette #(
  parameter int BYTE_W = 8,
  parameter logic [cbar_pkg::NUM_BARS*BYTE_W-1:0] TABLE = 64'h001F3C6996C3E0FF
) (
  input  logic [cbar_pkg::BAR_IDX_W-1:0] idx,
  output logic [BYTE_W-1:0]              value
);
  logic [BYTE_W-1:0] entry [cbar_pkg::NUM_BARS];

  for (genvar g = 0; g < cbar_pkg::NUM_BARS; g++) begin : g_entry
    assign entry[g] = TABLE[g*BYTE_W +: BYTE_W];
  end

  assign value = entry[idx];
endmodule

// File: rtl/cbar_line_seq.sv
module cbar_line_seq #(
  parameter int LB_W   = 15,
  parameter int BYTE_W = 8,
  parameter logic [cbar_pkg::NUM_BARS*BYTE_W-1:0] TABLE = 64'h001F3C6996C3E0FF
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          len_ok,
  input  logic [LB_W-1:0]               bar_bytes,
  input  logic [LB_W-1:0]               line_bytes,
  input  logic                          ready,
  output logic                          valid,
  output logic                          eol,
  output logic                          err,
  output logic [cbar_pkg::BAR_IDX_W-1:0] bar_idx,
  output logic [BYTE_W-1:0]             data
);
  localparam logic [cbar_pkg::BAR_IDX_W-1:0] LAST_BAR =
    cbar_pkg::BAR_IDX_W'(cbar_pkg::NUM_BARS - 1);

  logic                           busy_q, eol_q, err_q;
  logic [cbar_pkg::BAR_IDX_W-1:0] idx_q, idx_nxt;
  logic [LB_W-1:0]                byte_cnt_q, bar_cnt_q, size_q, last_q;
  logic [BYTE_W-1:0]              data_q, pal_val;
  logic                           load, step, bar_end;

  assign load    = start && !busy_q && len_ok;
  assign step    = busy_q && ready && !eol_q;
  assign bar_end = (bar_cnt_q == size_q - LB_W'(1)) && (idx_q != LAST_BAR);

  always_comb begin
    if (load)                idx_nxt = '0;
    else if (step && bar_end) idx_nxt = idx_q + 1'b1;
    else                     idx_nxt = idx_q;
  end

  cbar_palette #(.BYTE_W(BYTE_W), .TABLE(TABLE)) pal_i (
    .idx   (idx_nxt),
    .value (pal_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      eol_q      <= 1'b0;
      err_q      <= 1'b0;
      idx_q      <= '0;
      byte_cnt_q <= '0;
      bar_cnt_q  <= '0;
      size_q     <= '0;
      last_q     <= '0;
      data_q     <= '0;
    end else begin
      err_q <= start && !busy_q && !len_ok;
      if (load) begin
        busy_q     <= 1'b1;
        byte_cnt_q <= '0;
        bar_cnt_q  <= '0;
        idx_q      <= idx_nxt;
        size_q     <= bar_bytes;
        last_q     <= line_bytes - LB_W'(1);
        eol_q      <= (line_bytes == LB_W'(1));
        data_q     <= pal_val;
      end else if (busy_q && ready) begin
        if (eol_q) begin
          busy_q <= 1'b0;
          eol_q  <= 1'b0;
        end else begin
          byte_cnt_q <= byte_cnt_q + LB_W'(1);
          eol_q      <= (byte_cnt_q + LB_W'(1) == last_q);
          bar_cnt_q  <= bar_end ? '0 : bar_cnt_q + LB_W'(1);
          idx_q      <= idx_nxt;
          data_q     <= pal_val;
        end
      end
    end
  end

  assign valid   = busy_q;
  assign eol     = eol_q;
  assign err     = err_q;
  assign bar_idx = idx_q;
  assign data    = data_q;
endmodule

// File: rtl/cbar_pattern_gen.sv
module cbar_pattern_gen #(
  parameter int PIX_W  = 14,
  parameter int BYTE_W = 8,
  parameter logic [cbar_pkg::NUM_BARS*BYTE_W-1:0] TABLE = 64'h001F3C6996C3E0FF
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          dtype_sel,
  input  logic [PIX_W-1:0]              pix_len,
  input  logic                          sol_strobe,
  input  logic                          out_ready,
  output logic [BYTE_W-1:0]             out_byte,
  output logic                          out_valid,
  output logic [cbar_pkg::BAR_IDX_W-1:0] out_bar,
  output logic                          out_eol,
  output logic                          len_err
);
  localparam int LB_W = PIX_W + 1;

  logic            calc_ok;
  logic [LB_W-1:0] calc_bar, calc_line;

  cbar_size_calc #(.PIX_W(PIX_W)) calc_i (
    .dtype      (cbar_pkg::dtype_e'(dtype_sel)),
    .pix_len    (pix_len),
    .len_ok     (calc_ok),
    .bar_bytes  (calc_bar),
    .line_bytes (calc_line)
  );

  cbar_line_seq #(.LB_W(LB_W), .BYTE_W(BYTE_W), .TABLE(TABLE)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .start      (sol_strobe),
    .len_ok     (calc_ok),
    .bar_bytes  (calc_bar),
    .line_bytes (calc_line),
    .ready      (out_ready),
    .valid      (out_valid),
    .eol        (out_eol),
    .err        (len_err),
    .bar_idx    (out_bar),
    .data       (out_byte)
  );
endmodule

// File: rtl/cbar_checker.sv
module cbar_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              out_ready,
  input logic              out_valid,
  input logic              out_eol,
  input logic              len_err,
  input logic [2:0]        out_bar,
  input logic [BYTE_W-1:0] out_byte
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_bar) && $stable(out_eol)));

  assert_eol_valid_R6: assert property (@(posedge clk) disable iff (rst)
    out_eol |-> out_valid);

  assert_drop_after_eol_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eol) |=> !out_valid);

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (rst)
    len_err |-> !out_valid);

  assert_first_bar_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_bar == 3'd0));

  assert_bar_step_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_eol) |=> (out_bar == $past(out_bar) || out_bar == $past(out_bar) + 3'd1));

  assert_tail_stays_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_eol && out_bar == 3'd7) |=> (out_bar == 3'd7));
endmodule

bind cbar_pattern_gen cbar_checker #(.BYTE_W(BYTE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_eol   (out_eol),
  .len_err   (len_err),
  .out_bar   (out_bar),
  .out_byte  (out_byte)
);

// File: tb/cbar_pattern_gen_tb_top.sv
module cbar_pattern_gen_tb_top;
  localparam int PW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dtype_sel = 1'b0;
  logic [PW-1:0] pix_len = '0;
  logic          sol_strobe = 1'b0;
  logic          out_ready = 1'b0;
  logic [7:0]    out_byte;
  logic          out_valid;
  logic [2:0]    out_bar;
  logic          out_eol;
  logic          len_err;

  int total = 0;
  int bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  cbar_pattern_gen #(.PIX_W(PW)) dut_i (
    .clk(clk), .rst(rst), .dtype_sel(dtype_sel), .pix_len(pix_len),
    .sol_strobe(sol_strobe), .out_ready(out_ready), .out_byte(out_byte),
    .out_valid(out_valid), .out_bar(out_bar), .out_eol(out_eol), .len_err(len_err)
  );

  function automatic int color(int b);
    case (b)
      0: return 'hFF; 1: return 'hE0; 2: return 'hC3; 3: return 'h96;
      4: return 'h69; 5: return 'h3C; 6: return 'h1F; default: return 'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run_line(input bit t, input int p, input int rmode, input bit inject);
    int ppb, bpb, blocks, lb, bs, k, ebar, prev_byte, prev_bar;
    bit ok, done, stalled;
    ppb = t ? 2 : 4;
    bpb = t ? 3 : 5;
    blocks = p / ppb;
    ok = (p % ppb == 0) && (blocks >= 8);
    lb = blocks * bpb;
    bs = (blocks / 8) * bpb;
    @(negedge clk);
    dtype_sel = t; pix_len = PW'(p); sol_strobe = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    sol_strobe = 1'b0;
    #1;
    if (!ok) begin
      chk(len_err == 1'b1, "R7 err pulse", len_err, 1);
      chk(out_valid == 1'b0, "R7 no valid", out_valid, 0);
      @(negedge clk); #1;
      chk(len_err == 1'b0 && out_valid == 1'b0, "R7 pulse width", len_err, 0);
      return;
    end
    chk(out_valid == 1'b1, "R10 valid after strobe", out_valid, 1);
    chk(out_bar == 3'd0, "R10 first bar", out_bar, 0);
    chk(len_err == 1'b0, "R7 no err on good length", len_err, 0);
    k = 0; done = 0; stalled = 0; prev_byte = 0; prev_bar = 0;
    while (!done) begin
      sol_strobe = 1'b0;
      pix_len = PW'(p);
      next_lfsr();
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0];
        default: out_ready = lfsr[0] | lfsr[3];
      endcase
      if (stalled) begin
        chk(out_byte == prev_byte[7:0] && out_bar == prev_bar[2:0], "R5 held during stall", out_byte, prev_byte);
      end
      if (!out_valid) begin
        chk(0, "R6 valid dropped early", k, lb);
        done = 1;
      end else if (out_ready) begin
        ebar = (k / bs > 7) ? 7 : k / bs;
        chk(out_byte == color(ebar)[7:0], (k >= 8*bs) ? "R4 tail byte" : "R3 bar byte", out_byte, color(ebar));
        chk(out_bar == ebar[2:0], (k >= 8*bs) ? "R4 tail bar" : "R2 bar index", out_bar, ebar);
        chk(out_eol == (k == lb - 1), "R6 eol position", out_eol, (k == lb - 1));
        if (inject && k == lb / 2) begin
          sol_strobe = 1'b1;
          pix_len = PW'(p + 8*ppb);
        end
        if (out_eol) begin
          chk(k == lb - 1, "R1 line byte count", k + 1, lb);
          done = 1;
          if (inject) sol_strobe = 1'b1;
        end
        k++;
        stalled = 0;
      end else begin
        stalled = 1;
        prev_byte = out_byte;
        prev_bar = out_bar;
      end
      @(negedge clk); #1;
    end
    sol_strobe = 1'b0;
    chk(out_valid == 1'b0, inject ? "R8 strobe at last byte ignored" : "R6 valid falls", out_valid, 0);
    @(negedge clk); #1;
    chk(out_valid == 1'b0 && len_err == 1'b0, "R8 no new line", out_valid, 0);
  endtask

  initial begin
    #(4 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
    chk(out_eol == 1'b0, "R9 reset eol", out_eol, 0);
    chk(len_err == 1'b0, "R9 reset err", len_err, 0);
    chk(out_bar == 3'd0, "R9 reset bar", out_bar, 0);
    @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < 2; t++) begin
      for (int p = 0; p <= 160; p++) begin
        run_line(t[0], p, p % 3, (p % 5) == 0);
      end
    end
    run_line(1'b0, 1020, 2, 1'b1);
    run_line(1'b1, 1022, 1, 1'b0);
    run_line(1'b1, 1023, 0, 1'b0);
    run_line(1'b0, 1022, 0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule